// File: doc/BRIEF.md
# Shared Hardware Semaphore Bank

This block holds a bank of small lock registers that several processors share through a simple register bus with more than one port. Each gate stores the tag of the processor that holds it, or zero when it is free. A processor's tag is its bus master ID plus one. To claim a gate, a processor writes its tag to the gate and then reads the gate back. Seeing its own tag means it won. Seeing any other value means another processor got there first. Only the holder can release a gate, and it does so by writing zero.

A protected clearing path returns one gate, or every gate, to the free state. This covers the case where a holder has crashed. Bringing the block out of reset, or enabling it, never clears gates that live processors may hold. Clearing is done only through a key register, which needs an arming key followed by a firing key that names the target. The key register reports the sequencer's progress so that software can wait until it is idle before starting a new sequence.

Top module: `sema_bank`

## Requirements
- R1: After the synchronous reset every gate reads 0 and the key register status reads 0 (idle).
- R2: A bus write whose data equals the writer's tag (master ID + 1, all upper data bits zero) to a gate that reads 0 makes the gate read that tag from the next cycle on. Any other value written to a free gate leaves it at 0. Master ID 15 has no valid tag and can never lock.
- R3: A write to a gate holding a nonzero tag from a master whose tag differs from it leaves the gate unchanged.
- R4: The holder writing 0 frees the gate. A write of 0 from any other master leaves the gate unchanged.
- R5: When several ports write valid tags to the same free gate in one cycle, the lowest master ID wins. Writes to different gates in the same cycle act independently.
- R6: Gates sit at addresses 0 to NUM_GATES-1, with the value on rdata[3:0]. The key register is at address NUM_GATES, with its status on rdata[1:0]: 0 idle, 1 armed, 2 clearing. Other addresses read 0. In a key write, the key is wdata[7:0] and the target gate number is wdata[15:8].
- R7: Writing key 0xE2 while idle arms the sequencer (status 1). A following write of key 0x1D from the same master moves it to status 2 for exactly one cycle. At the end of that cycle the target is cleared and the status returns to 0.
- R8: A target of 64 or more clears every gate. A target from NUM_GATES to 63 clears nothing.
- R9: While armed, a key write with any key other than 0x1D returns the sequencer to idle without clearing. A key write other than 0xE2 while idle leaves it idle.
- R10: While armed, a key write from a master other than the one that armed it aborts to idle without clearing.
- R11: When a clear and a lock write hit the same gate in the same cycle, the clear wins and the gate reads 0.
- R12: Key register writes during the clearing cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | NUM_PORTS | Write strobe per bus port |
| bus_addr | input | NUM_PORTS*ADDR_W | Register address per port (read and write) |
| bus_wdata | input | NUM_PORTS*16 | Write data per port |
| bus_mid | input | NUM_PORTS*4 | Master ID that goes with each port's access |
| bus_rdata | output | NUM_PORTS*8 | Combinational read data per port |

## Verification
A clear issued by the key sequencer can land in the same cycle as a lock write to the target gate. It can also coincide with a new arming key sent to the key register. The bench provokes both cases together. It fires a clear of one gate, and in the clearing cycle it uses one port to write a lock to that gate and the other port to write 0xE2 to the key register. The gate must then read 0 and the status must read idle. Same-cycle lock contention between the two ports is judged in the same way, by reading back which tag survived.

// File: rtl/sema_pkg.sv
`timescale 1ns/1ps
package sema_pkg;

    localparam int MID_W    = 4;
    localparam int GATE_W   = 4;
    localparam int DATA_W   = 16;
    localparam int RD_W     = 8;
    localparam int KEY_W    = 8;
    localparam int TARGET_W = DATA_W - KEY_W;

    localparam logic [KEY_W-1:0]    KEY_ARM    = 8'hE2;
    localparam logic [KEY_W-1:0]    KEY_FIRE   = 8'h1D;
    localparam logic [TARGET_W-1:0] TARGET_ALL = 8'd64;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_CLEAR = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              en;
        logic [MID_W-1:0]  mid;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic [GATE_W-1:0] tag_of(input logic [MID_W-1:0] mid);
        return GATE_W'(mid + MID_W'(1));
    endfunction

    function automatic logic [KEY_W-1:0] key_of(input logic [DATA_W-1:0] d);
        return d[KEY_W-1:0];
    endfunction

    function automatic logic [TARGET_W-1:0] target_of(input logic [DATA_W-1:0] d);
        return d[DATA_W-1:KEY_W];
    endfunction

endpackage

// File: rtl/sema_gate.sv
`timescale 1ns/1ps
module sema_gate
    import sema_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  wr_req_t [NUM_PORTS-1:0]       req,
    input  logic                          clr,
    output logic [GATE_W-1:0]             q
);

    logic              lock_hit;
    logic [MID_W-1:0]  best_mid;
    logic              unlock_hit;
    logic              any_req;
    logic [GATE_W-1:0] q_next;

    always_comb begin
        logic [GATE_W-1:0] t;
        lock_hit   = 1'b0;
        best_mid   = '1;
        unlock_hit = 1'b0;
        any_req    = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            t = tag_of(req[p].mid);
            if (req[p].en) any_req = 1'b1;
            if (req[p].en && t != '0 && req[p].data == DATA_W'(t)) begin
                if (!lock_hit || req[p].mid < best_mid) begin
                    lock_hit = 1'b1;
                    best_mid = req[p].mid;
                end
            end
            if (req[p].en && req[p].data == '0 && q != '0 && q == t)
                unlock_hit = 1'b1;
        end
    end

    always_comb begin
        if (clr)
            q_next = '0;
        else if (q == '0 && lock_hit)
            q_next = tag_of(best_mid);
        else if (unlock_hit)
            q_next = '0;
        else
            q_next = q;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end

    // R3
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (q != '0) |=> (q == '0 || $stable(q)));

    // R11
    clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));

    // R2
    free_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (q == '0 && !any_req) |=> (q == '0));

endmodule

// File: rtl/sema_keyseq.sv
`timescale 1ns/1ps
module sema_keyseq
    import sema_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int NUM_GATES = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t [NUM_PORTS-1:0]  req,
    output seq_state_e               state,
    output logic [NUM_GATES-1:0]     clr_mask
);

    localparam int GIDX_W = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1;

    seq_state_e          state_q;
    logic [MID_W-1:0]    owner_q;
    logic [TARGET_W-1:0] target_q;

    logic                sel_hit;
    logic [MID_W-1:0]    sel_mid;
    logic [DATA_W-1:0]   sel_data;

    always_comb begin
        sel_hit  = 1'b0;
        sel_mid  = '1;
        sel_data = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req[p].en && (!sel_hit || req[p].mid < sel_mid)) begin
                sel_hit  = 1'b1;
                sel_mid  = req[p].mid;
                sel_data = req[p].data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            owner_q  <= '0;
            target_q <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (sel_hit && key_of(sel_data) == KEY_ARM) begin
                        state_q <= SEQ_ARMED;
                        owner_q <= sel_mid;
                    end
                end
                SEQ_ARMED: begin
                    if (sel_hit) begin
                        if (key_of(sel_data) == KEY_FIRE && sel_mid == owner_q) begin
                            state_q  <= SEQ_CLEAR;
                            target_q <= target_of(sel_data);
                        end else begin
                            state_q <= SEQ_IDLE;
                        end
                    end
                end
                SEQ_CLEAR: state_q <= SEQ_IDLE;
                default:   state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        clr_mask = '0;
        if (state_q == SEQ_CLEAR) begin
            if (target_q >= TARGET_ALL)
                clr_mask = '1;
            else if (target_q < TARGET_W'(NUM_GATES))
                clr_mask[target_q[GIDX_W-1:0]] = 1'b1;
        end
    end

    assign state = state_q;

    // R7
    clear_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_CLEAR) |=> (state_q == SEQ_IDLE));

    // R7
    clear_from_armed_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_ARMED && !sel_hit) |=> (state_q == SEQ_ARMED));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE && !sel_hit) |=> (state_q == SEQ_IDLE));

    // R8
    mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
        ($onehot0(clr_mask) || clr_mask == '1));

endmodule

// File: rtl/sema_rdport.sv
`timescale 1ns/1ps
module sema_rdport
    import sema_pkg::*;
#(
    parameter int NUM_GATES = 16,
    parameter int ADDR_W    = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [GATE_W-1:0] gates [NUM_GATES],
    input  seq_state_e        state,
    output logic [RD_W-1:0]   rdata
);

    always_comb begin
        rdata = '0;
        for (int g = 0; g < NUM_GATES; g++) begin
            if (addr == ADDR_W'(g))
                rdata = RD_W'(gates[g]);
        end
        if (addr == ADDR_W'(NUM_GATES))
            rdata = RD_W'(state);
    end

endmodule

// File: rtl/sema_bank.sv
`timescale 1ns/1ps
module sema_bank
    import sema_pkg::*;
#(
    parameter int NUM_GATES = 16,
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = $clog2(NUM_GATES + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PORTS-1:0]          bus_we,
    input  logic [NUM_PORTS*ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PORTS*DATA_W-1:0]   bus_wdata,
    input  logic [NUM_PORTS*MID_W-1:0]    bus_mid,
    output logic [NUM_PORTS*RD_W-1:0]     bus_rdata
);

    localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(NUM_GATES);

    logic [ADDR_W-1:0]       port_addr [NUM_PORTS];
    wr_req_t [NUM_PORTS-1:0] port_req;
    wr_req_t [NUM_PORTS-1:0] gate_req [NUM_GATES];
    wr_req_t [NUM_PORTS-1:0] key_req;
    logic [GATE_W-1:0]       gate_q [NUM_GATES];
    logic [NUM_GATES-1:0]    clr_mask;
    seq_state_e              seq_state;

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            port_addr[p]     = bus_addr[p*ADDR_W +: ADDR_W];
            port_req[p].en   = bus_we[p];
            port_req[p].mid  = bus_mid[p*MID_W +: MID_W];
            port_req[p].data = bus_wdata[p*DATA_W +: DATA_W];
        end
    end

    always_comb begin
        for (int g = 0; g < NUM_GATES; g++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                gate_req[g][p]    = port_req[p];
                gate_req[g][p].en = port_req[p].en && (port_addr[p] == ADDR_W'(g));
            end
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            key_req[p]    = port_req[p];
            key_req[p].en = port_req[p].en && (port_addr[p] == KEY_ADDR);
        end
    end

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        sema_gate #(.NUM_PORTS(NUM_PORTS)) u_gate (
            .clk (clk),
            .rst (rst),
            .req (gate_req[g]),
            .clr (clr_mask[g]),
            .q   (gate_q[g])
        );
    end

    sema_keyseq #(.NUM_PORTS(NUM_PORTS), .NUM_GATES(NUM_GATES)) u_keyseq (
        .clk      (clk),
        .rst      (rst),
        .req      (key_req),
        .state    (seq_state),
        .clr_mask (clr_mask)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        sema_rdport #(.NUM_GATES(NUM_GATES), .ADDR_W(ADDR_W)) u_rd (
            .addr  (port_addr[p]),
            .gates (gate_q),
            .state (seq_state),
            .rdata (bus_rdata[p*RD_W +: RD_W])
        );
    end

endmodule

// File: tb/sema_bank_bench.sv
`timescale 1ns/1ps
module sema_bank_bench;

    localparam int NG = 16;
    localparam int NP = 2;
    localparam int AW = 5;
    localparam int KA = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NP-1:0]    we = '0;
    logic [NP*AW-1:0] addr = '0;
    logic [NP*16-1:0] wdata = '0;
    logic [NP*4-1:0]  mid = '0;
    logic [NP*8-1:0]  rdata;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sema_bank #(.NUM_GATES(NG), .NUM_PORTS(NP)) u_sema_bank (
        .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_mid(mid), .bus_rdata(rdata)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic rd(input int p, input int a, output int v);
        addr[p*AW +: AW] = AW'(a);
        #0.2;
        v = int'(rdata[p*8 +: 8]);
        @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        int v;
        rd(0, a, v);
        chk(req, v, exp);
    endtask

    task automatic wr(input int p, input int a, input int d, input int m);
        we[p] = 1'b1;
        addr[p*AW +: AW] = AW'(a);
        wdata[p*16 +: 16] = 16'(d);
        mid[p*4 +: 4] = 4'(m);
        @(posedge clk);
        @(negedge clk);
        we[p] = 1'b0;
    endtask

    task automatic wr2(input int a0, input int d0, input int m0,
                       input int a1, input int d1, input int m1);
        we = 2'b11;
        addr[0 +: AW] = AW'(a0);  addr[AW +: AW] = AW'(a1);
        wdata[0 +: 16] = 16'(d0); wdata[16 +: 16] = 16'(d1);
        mid[0 +: 4] = 4'(m0);     mid[4 +: 4] = 4'(m1);
        @(posedge clk);
        @(negedge clk);
        we = '0;
    endtask

    task automatic t_reset();
        for (int g = 0; g < NG; g++) rd_chk("R1 gate free", g, 0);
        rd_chk("R1 status idle", KA, 0);
        rd_chk("R6 unmapped address", 31, 0);
    endtask

    task automatic t_lock();
        wr(0, 5, 3, 2);
        rd_chk("R2 lock by tag", 5, 3);
        wr(1, 5, 5, 4);
        rd_chk("R3 held gate kept", 5, 3);
        wr(0, 6, 7, 4);
        rd_chk("R2 wrong tag ignored", 6, 0);
        wr(0, 6, 16'h0105, 4);
        rd_chk("R2 upper bits set ignored", 6, 0);
        wr(0, 7, 0, 15);
        rd_chk("R2 master 15 cannot lock", 7, 0);
    endtask

    task automatic t_unlock();
        wr(1, 5, 0, 4);
        rd_chk("R4 non-owner zero ignored", 5, 3);
        wr(0, 5, 0, 2);
        rd_chk("R4 owner frees", 5, 0);
        wr(1, 5, 5, 4);
        rd_chk("R2 relock after free", 5, 5);
    endtask

    task automatic t_race();
        wr2(9, 8, 7, 9, 4, 3);
        rd_chk("R5 lower id wins port1", 9, 4);
        wr2(10, 2, 1, 10, 7, 6);
        rd_chk("R5 lower id wins port0", 10, 2);
        wr2(11, 3, 2, 12, 6, 5);
        rd_chk("R5 independent gate a", 11, 3);
        rd_chk("R5 independent gate b", 12, 6);
    endtask

    task automatic t_clear_one();
        wr(0, KA, 8'hE2, 1);
        rd_chk("R7 armed status", KA, 1);
        wr(0, KA, (9 << 8) | 8'h1D, 1);
        rd_chk("R7 clearing status", KA, 2);
        rd_chk("R7 back to idle", KA, 0);
        rd_chk("R7 target cleared", 9, 0);
        rd_chk("R7 other gate kept", 10, 2);
    endtask

    task automatic t_clear_range();
        wr(0, KA, 8'hE2, 1);
        wr(0, KA, (20 << 8) | 8'h1D, 1);
        @(negedge clk);
        rd_chk("R8 mid-range target no effect", 5, 5);
        rd_chk("R8 mid-range target no effect", 10, 2);
        wr(0, KA, 8'hE2, 1);
        wr(0, KA, (64 << 8) | 8'h1D, 1);
        @(negedge clk);
        rd_chk("R8 clear all", 5, 0);
        rd_chk("R8 clear all", 10, 0);
        rd_chk("R8 clear all", 11, 0);
        rd_chk("R8 clear all", 12, 0);
    endtask

    task automatic t_abort();
        wr(0, 3, 3, 2);
        wr(0, KA, 8'hE2, 1);
        wr(0, KA, 8'h55, 1);
        rd_chk("R9 bad second key idles", KA, 0);
        rd_chk("R9 nothing cleared", 3, 3);
        wr(0, KA, (3 << 8) | 8'h1D, 1);
        rd_chk("R9 lone fire key idle", KA, 0);
        rd_chk("R9 lone fire no clear", 3, 3);
        wr(0, KA, 8'hE2, 1);
        wr(1, KA, (3 << 8) | 8'h1D, 2);
        rd_chk("R10 foreign fire aborts", KA, 0);
        @(negedge clk);
        rd_chk("R10 foreign fire no clear", 3, 3);
    endtask

    task automatic t_clash();
        wr(0, KA, 8'hE2, 1);
        wr(0, KA, (4 << 8) | 8'h1D, 1);
        wr2(KA, 8'hE2, 1, 4, 6, 5);
        rd_chk("R11 clear beats lock", 4, 0);
        rd_chk("R12 key ignored while clearing", KA, 0);
        wr(1, 4, 6, 5);
        rd_chk("R11 gate usable after clash", 4, 6);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_lock();
        t_unlock();
        t_race();
        t_clear_one();
        t_clear_range();
        t_abort();
        t_clash();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule